// File: doc/BRIEF.md
# Dual-Compare PWM Timer Channel

A single 16-bit timer channel whose counter advances on a selectable count enable and is compared against two general compare values. In PWM mode a hit on compare value A drives the output pin high and a hit on compare value B drives it low, so the two registers place the rising and the falling edge of the waveform independently. Either hit may also be chosen to zero the counter, which fixes the period. This lets the duty cycle run anywhere from 0% to 100%.

Software programs the channel through a single write port: a control word, the counter itself, the two compare values, and a write-one-to-clear flag register. The count enable comes from an internal divider of the system clock or from one of four external clock lines. Each external line passes through a synchronizer and an edge detector. Each compare hit also sets a sticky flag.

Top module: `pwm_tmr_ch`

## Requirements
- R1: After reset, `pwm_out`, both flags and the counter are 0, and the control word is all zero, so counting is stopped.
- R2: The counter advances by one on a count enable, and count enables occur only while control bit 8 (start) is 1. With start at 0 the counter holds and no compare hit occurs.
- R3: Control bits 2:0 select the count source. Codes 0 to 3 give an enable every 1, 2, 4 or 8 system clocks. The enable is taken from a 3-bit divider that counts every clock from reset and fires when its low `code` bits are all zero.
- R4: Codes 4 to 7 select `ext_clk[0]` to `ext_clk[3]`. The chosen line passes through two synchronizing flops and a previous-value flop. Control bits 4:3 pick the edge that makes an enable: 0 rising, 1 falling, 2 or 3 both. An edge reaches the counter on the third clock edge after the input changes.
- R5: A compare is taken on the counter value before it steps. When the counter equals A on an enable, `pwm_out` becomes 1 on that clock edge. When it equals B, `pwm_out` becomes 0.
- R6: Control bits 6:5 choose the clear source: 1 is the hit on A, 2 is the hit on B, 0 and 3 mean none. On a clearing hit the counter loads 0 instead of stepping, which gives a period of compare+1 enables. Duty cycles of 0% and 100% can be reached this way.
- R7: When A and B hold the same value, a hit leaves `pwm_out` unchanged.
- R8: `pwm_out` changes only while control bit 7 (PWM enable) is 1. Otherwise it holds its level.
- R9: A write to address 1 loads the counter on that clock edge, and the write takes precedence over a step or a clear in the same cycle.
- R10: Each hit on A sets `cmp_flag_a` and each hit on B sets `cmp_flag_b`. Writing address 4 with data bit 0 (or bit 1) set clears the flag for A (or B). A 0 bit leaves its flag alone, and a hit in the same cycle as a clear wins. Address 2 writes A and address 3 writes B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 counter, 2 compare A, 3 compare B, 4 flag clear |
| wr_data | input | 16 | Register write data |
| ext_clk | input | 4 | External count clock lines |
| pwm_out | output | 1 | PWM waveform |
| cmp_flag_a | output | 1 | Sticky compare-hit flag for A |
| cmp_flag_b | output | 1 | Sticky compare-hit flag for B |

## Verification
A reference model of the requirements predicts the pin and both flags on every cycle. It is driven through several settings. Setting A below B while clearing on B gives a plain pulse train, and B below A while clearing on A swaps the edge order, which shows whether set and reset are wired to the correct compare. Equal compare values, a set point beyond the period and a zero set point with clear on A cover the hold, 0% and 100% cases. Each divider code and each external line under every edge mode tell apart the enable paths and their latency, while writes to the counter and the flags in mid-run check that the counter write and the flag clear take precedence as the requirements state.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  localparam int SRC_W = 3;
  localparam int PRE_W = 3;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    CLR_OFF   = 2'd0,
    CLR_ON_A  = 2'd1,
    CLR_ON_B  = 2'd2,
    CLR_OFF2  = 2'd3
  } clr_sel_e;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'd0,
    EDGE_FALL  = 2'd1,
    EDGE_ANY   = 2'd2,
    EDGE_ANY2  = 2'd3
  } edge_sel_e;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_CNT  = 3'd1,
    REG_CMPA = 3'd2,
    REG_CMPB = 3'd3,
    REG_FLAG = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic             start;
    logic             pwm_en;
    clr_sel_e         clr;
    edge_sel_e        edg;
    logic [SRC_W-1:0] src;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [PRE_W-1:0] div_mask(input logic [1:0] code);
    logic [PRE_W:0] one_hot;
    one_hot = (PRE_W+1)'(1) << code;
    return PRE_W'(one_hot - (PRE_W+1)'(1));
  endfunction

  function automatic logic pwm_next(input logic cur, input logic en,
                                    input logic hit_a, input logic hit_b);
    if (!en || (hit_a && hit_b)) return cur;
    if (hit_a) return 1'b1;
    if (hit_b) return 1'b0;
    return cur;
  endfunction

  function automatic logic clears_on(input clr_sel_e sel,
                                     input logic hit_a, input logic hit_b);
    return ((sel == CLR_ON_A) && hit_a) || ((sel == CLR_ON_B) && hit_b);
  endfunction

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  cmp_a,
  output logic [CNT_W-1:0]  cmp_b,
  output logic              cnt_wr,
  output logic [1:0]        flag_clr
);

  logic sel_ctrl, sel_a, sel_b, sel_flag;

  assign sel_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign sel_a    = wr_en && (wr_addr == REG_CMPA);
  assign sel_b    = wr_en && (wr_addr == REG_CMPB);
  assign sel_flag = wr_en && (wr_addr == REG_FLAG);
  assign cnt_wr   = wr_en && (wr_addr == REG_CNT);
  assign flag_clr = sel_flag ? wr_data[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      cmp_a <= '0;
      cmp_b <= '0;
    end else begin
      if (sel_ctrl) ctrl  <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (sel_a)    cmp_a <= wr_data;
      if (sel_b)    cmp_b <= wr_data;
    end
  end

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctrl |=> ctrl == $past(wr_data[CTRL_W-1:0]));

  assert_ctrl_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ctrl |=> $stable(ctrl));

endmodule

// File: rtl/pwm_tmr_tick.sv
module pwm_tmr_tick
  import pwm_tmr_pkg::*;
#(
  parameter int N_EXT  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_clk,
  input  logic [SRC_W-1:0] src,
  input  edge_sel_e        edg,
  input  logic             start,
  output logic             cnt_tick
);

  localparam int EXT_SEL_W = $clog2(N_EXT);

  logic [PRE_W-1:0] pre_cnt;
  logic             int_tick;
  logic [N_EXT-1:0] ext_rise, ext_fall;
  logic             sel_rise, sel_fall, ext_hit;
  logic             use_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + PRE_W'(1);
  end

  assign int_tick = (pre_cnt & div_mask(src[1:0])) == '0;

  for (genvar g = 0; g < N_EXT; g++) begin : g_sync
    logic [SYNC_N-1:0] sh;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[SYNC_N-2:0], ext_clk[g]};
        prev <= sh[SYNC_N-1];
      end
    end
    assign ext_rise[g] = sh[SYNC_N-1] && !prev;
    assign ext_fall[g] = !sh[SYNC_N-1] && prev;

    assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise[g] |=> !ext_rise[g]);
    assert_fall_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ext_fall[g] |=> !ext_fall[g]);
  end

  assign sel_rise = ext_rise[src[EXT_SEL_W-1:0]];
  assign sel_fall = ext_fall[src[EXT_SEL_W-1:0]];

  always_comb begin
    unique case (edg)
      EDGE_RISE: ext_hit = sel_rise;
      EDGE_FALL: ext_hit = sel_fall;
      default:   ext_hit = sel_rise || sel_fall;
    endcase
  end

  assign use_ext  = src[SRC_W-1];
  assign cnt_tick = start && (use_ext ? ext_hit : int_tick);

  assert_div8_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_tick && src == 3'd3) |=> (!int_tick || src != 3'd3));

  assert_div1_every_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && src == 3'd0) |-> cnt_tick);

endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  clr_sel_e         clr,
  output logic             hit_a,
  output logic             hit_b
);

  logic [CNT_W-1:0] cnt;
  logic             clear_hit;

  assign hit_a     = cnt_tick && (cnt == cmp_a);
  assign hit_b     = cnt_tick && (cnt == cmp_b);
  assign clear_hit = clears_on(clr, hit_a, hit_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (cnt_wr)    cnt <= wr_data;
    else if (cnt_tick)  cnt <= clear_hit ? '0 : cnt + CNT_W'(1);
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !clear_hit && !cnt_wr) |=> cnt == $past(cnt) + CNT_W'(1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !cnt_wr) |=> $stable(cnt));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && clear_hit && !cnt_wr) |=> cnt == '0);

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wr_data));

endmodule

// File: rtl/pwm_tmr_out.sv
module pwm_tmr_out
  import pwm_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic       pwm_en,
  input  logic [1:0] flag_clr,
  output logic       pwm_out,
  output logic       flag_a,
  output logic       flag_b
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_out <= 1'b0;
      flag_a  <= 1'b0;
      flag_b  <= 1'b0;
    end else begin
      pwm_out <= pwm_next(pwm_out, pwm_en, hit_a, hit_b);
      flag_a  <= hit_a || (flag_a && !flag_clr[0]);
      flag_b  <= hit_b || (flag_b && !flag_clr[1]);
    end
  end

  assert_set_on_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && hit_a && !hit_b) |=> pwm_out);

  assert_reset_on_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && hit_b && !hit_a) |=> !pwm_out);

  assert_equal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && hit_b) |=> $stable(pwm_out));

  assert_mode_off_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> $stable(pwm_out));

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a |=> flag_a) and (hit_b |=> flag_b));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !hit_a) |=> !flag_a);

endmodule

// File: rtl/pwm_tmr_ch.sv
module pwm_tmr_ch
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_EXT  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [N_EXT-1:0]  ext_clk,
  output logic              pwm_out,
  output logic              cmp_flag_a,
  output logic              cmp_flag_b
);

  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp_a, cmp_b;
  logic             cnt_wr;
  logic [1:0]       flag_clr;
  logic             cnt_tick;
  logic             hit_a, hit_b;

  pwm_tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cnt_wr(cnt_wr), .flag_clr(flag_clr)
  );

  pwm_tmr_tick #(.N_EXT(N_EXT), .SYNC_N(SYNC_N)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .src(ctrl.src),
    .edg(ctrl.edg), .start(ctrl.start), .cnt_tick(cnt_tick)
  );

  pwm_tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_wr(cnt_wr),
    .wr_data(wr_data), .cmp_a(cmp_a), .cmp_b(cmp_b), .clr(ctrl.clr),
    .hit_a(hit_a), .hit_b(hit_b)
  );

  pwm_tmr_out u_out (
    .clk(clk), .rst_n(rst_n), .hit_a(hit_a), .hit_b(hit_b),
    .pwm_en(ctrl.pwm_en), .flag_clr(flag_clr), .pwm_out(pwm_out),
    .flag_a(cmp_flag_a), .flag_b(cmp_flag_b)
  );

  assert_no_hit_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.start |-> !(hit_a || hit_b));

endmodule

// File: tb/pwm_tmr_ch_bench.sv
module pwm_tmr_ch_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  ext_clk = '0;
  logic        pwm_out, cmp_flag_a, cmp_flag_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_tmr_ch u_pwm_tmr_ch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_clk(ext_clk), .pwm_out(pwm_out),
    .cmp_flag_a(cmp_flag_a), .cmp_flag_b(cmp_flag_b)
  );

  // reference model state, written from the requirements
  logic [2:0]  m_pre, m_src;
  logic [1:0]  m_edg, m_clr;
  logic        m_pwm, m_start, m_out, m_fa, m_fb;
  logic [15:0] m_cnt, m_ca, m_cb;
  logic [3:0]  m_s1, m_s2, m_p;
  logic [2:0]  sb[$];

  always @(posedge clk) begin
    logic [2:0] mask;
    logic tk, ev, ha, hb, clr_hit, r, f;
    if (!rst_n) begin
      m_pre = 0; m_src = 0; m_edg = 0; m_clr = 0; m_pwm = 0; m_start = 0;
      m_out = 0; m_fa = 0; m_fb = 0; m_cnt = 0; m_ca = 0; m_cb = 0;
      m_s1 = 0; m_s2 = 0; m_p = 0;
    end else begin
      case (m_src[1:0])
        2'd0: mask = 3'b000;
        2'd1: mask = 3'b001;
        2'd2: mask = 3'b011;
        default: mask = 3'b111;
      endcase
      r = m_s2[m_src[1:0]] & ~m_p[m_src[1:0]];
      f = ~m_s2[m_src[1:0]] & m_p[m_src[1:0]];
      ev = (m_edg == 2'd0) ? r : (m_edg == 2'd1) ? f : (r | f);
      tk = m_start && (m_src[2] ? ev : ((m_pre & mask) == 0));
      ha = tk && (m_cnt == m_ca);
      hb = tk && (m_cnt == m_cb);
      clr_hit = (m_clr == 2'd1 && ha) || (m_clr == 2'd2 && hb);
      if (m_pwm && ha && !hb) m_out = 1'b1;
      else if (m_pwm && hb && !ha) m_out = 1'b0;
      if (ha) m_fa = 1'b1;
      else if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_fa = 1'b0;
      if (hb) m_fb = 1'b1;
      else if (wr_en && wr_addr == 3'd4 && wr_data[1]) m_fb = 1'b0;
      if (wr_en && wr_addr == 3'd1) m_cnt = wr_data;
      else if (tk) m_cnt = clr_hit ? 16'd0 : m_cnt + 16'd1;
      if (wr_en && wr_addr == 3'd0)
        {m_start, m_pwm, m_clr, m_edg, m_src} = wr_data[8:0];
      if (wr_en && wr_addr == 3'd2) m_ca = wr_data;
      if (wr_en && wr_addr == 3'd3) m_cb = wr_data;
      m_pre = m_pre + 3'd1;
      m_p = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
    end
    sb.push_back({m_out, m_fa, m_fb});
  end

  // monitor: compare the design against the queued expectations
  always @(negedge clk) begin
    logic [2:0] e;
    if (sb.size() > 0 && !done) begin
      e = sb.pop_front();
      checks++;
      if ({pwm_out, cmp_flag_a, cmp_flag_b} !== e) begin
        errors++;
        $display("FAIL %s scoreboard {pwm,fa,fb} got %b exp %b at %0t",
                 cur_req, {pwm_out, cmp_flag_a, cmp_flag_b}, e, $time);
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b exp %b", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [2:0] src, input logic [1:0] edg,
                                     input logic [1:0] clr, input logic pwm, input logic st);
    return {7'd0, st, pwm, clr, edg, src};
  endfunction

  task automatic setup(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    wr(3'd0, 16'd0);
    wr(3'd2, a);
    wr(3'd3, b);
    wr(3'd1, 16'd0);
    wr(3'd4, 16'd3);
    wr(3'd0, c);
  endtask

  task automatic ext_pulse(input int idx);
    @(negedge clk); ext_clk[idx] = 1'b1;
    idle(4);
    ext_clk[idx] = 1'b0;
    idle(4);
  endtask

  initial begin
    logic keep;
    idle(3);
    cur_req = "R1";
    chk(pwm_out, 1'b0, "R1", "pwm after reset");
    chk(cmp_flag_a | cmp_flag_b, 1'b0, "R1", "flags after reset");
    rst_n = 1'b1;
    idle(20);
    chk(cmp_flag_a | cmp_flag_b, 1'b0, "R1", "flags idle with control zero");

    cur_req = "R5";  // A below B, clear on B
    setup(16'd3, 16'd7, mk(3'd0, 2'd0, 2'd2, 1'b1, 1'b1));
    idle(40);
    chk(cmp_flag_a & cmp_flag_b, 1'b1, "R5", "both flags after pulse train");

    cur_req = "R10";
    wr(3'd0, mk(3'd0, 2'd0, 2'd2, 1'b1, 1'b0));
    wr(3'd4, 16'd0);
    chk(cmp_flag_a & cmp_flag_b, 1'b1, "R10", "zero write keeps flags");
    wr(3'd4, 16'd2);
    chk(cmp_flag_a, 1'b1, "R10", "flag A kept on bit1 clear");
    chk(cmp_flag_b, 1'b0, "R10", "flag B cleared");

    cur_req = "R2";
    wr(3'd4, 16'd3);
    idle(30);
    chk(cmp_flag_a | cmp_flag_b, 1'b0, "R2", "no hit while stopped");

    cur_req = "R6";  // B below A, clear on A
    setup(16'd5, 16'd2, mk(3'd0, 2'd0, 2'd1, 1'b1, 1'b1));
    idle(30);
    wr(3'd4, 16'd1);   // clear A while running
    idle(20);

    cur_req = "R7";
    setup(16'd4, 16'd4, mk(3'd0, 2'd0, 2'd1, 1'b1, 1'b1));
    keep = pwm_out;
    idle(40);
    chk(pwm_out, keep, "R7", "equal compares hold output");
    chk(cmp_flag_a & cmp_flag_b, 1'b1, "R7", "equal compares still flag");

    cur_req = "R6";  // 0 percent: set point never reached
    setup(16'd9, 16'd5, mk(3'd0, 2'd0, 2'd2, 1'b1, 1'b1));
    idle(30);
    chk(pwm_out, 1'b0, "R6", "zero duty");
    setup(16'd0, 16'd9, mk(3'd0, 2'd0, 2'd1, 1'b1, 1'b1));
    idle(30);
    chk(pwm_out, 1'b1, "R6", "full duty");

    cur_req = "R8";
    setup(16'd2, 16'd6, mk(3'd0, 2'd0, 2'd2, 1'b0, 1'b1));
    keep = pwm_out;
    idle(30);
    chk(pwm_out, keep, "R8", "output held with mode off");

    cur_req = "R3";
    for (int c = 1; c < 4; c++) begin
      setup(16'd2, 16'd5, mk(3'(c), 2'd0, 2'd2, 1'b1, 1'b1));
      idle(70);
    end

    cur_req = "R9";
    wr(3'd0, 16'd0);
    wr(3'd3, 16'h1234);
    wr(3'd2, 16'hF000);
    wr(3'd4, 16'd3);
    wr(3'd0, mk(3'd0, 2'd0, 2'd0, 1'b1, 1'b1));
    wr(3'd1, 16'h1230);
    idle(2);
    chk(cmp_flag_b, 1'b0, "R9", "flag B before loaded count reaches B");
    idle(4);
    chk(cmp_flag_b, 1'b1, "R9", "flag B after loaded count reaches B");
    setup(16'd3, 16'd7, mk(3'd0, 2'd0, 2'd2, 1'b1, 1'b1));
    idle(6);
    wr(3'd1, 16'd6);
    idle(20);

    cur_req = "R4";
    for (int i = 0; i < 4; i++) begin
      for (int e = 0; e < 3; e++) begin
        setup(16'd3, 16'd40, mk(3'(4 + i), 2'(e), 2'd1, 1'b1, 1'b1));
        if (e == 2) begin
          ext_pulse(i);
          chk(cmp_flag_a, 1'b0, "R4", "both edges, one pulse");
          ext_pulse(i);
          chk(cmp_flag_a, 1'b1, "R4", "both edges, two pulses");
        end else begin
          repeat (3) ext_pulse(i);
          chk(cmp_flag_a, 1'b0, "R4", "single edge, three pulses");
          ext_pulse(i);
          chk(cmp_flag_a, 1'b1, "R4", "single edge, four pulses");
        end
      end
    end

    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog run did not finish got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule